// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block brings an asynchronous DRAM array out of power-up and then keeps its rows alive. After reset it keeps the memory untouched for a programmable pause. It then runs a fixed burst of warm-up refresh cycles, and only after that does it declare the memory ready for normal traffic. From then on an interval timer marks a refresh as due once per average refresh period: the retention time divided by the row count. For 4096 rows in 64 ms at a 5 ns clock, that period is 3125 cycles. Due refreshes pile up in a small backlog counter while the bus is busy.

The scheduler shares the strobe pins with an access sequencer through a request/grant handshake that follows valid/ready rules. `bus_req` acts as valid and `bus_gnt` acts as ready, and a transfer happens on a clock edge where both are high. Once raised, the request is held until a grant arrives, and it does not change while it waits. A grant with no request pending does nothing. After the handshake the scheduler owns RAS, CAS and WE for one full refresh. Each refresh uses the CAS-before-RAS order, so no address is needed. The block has no data pins, and the sequencer keeps the data bus released while `bus_own` is high. All timings are counted in clock cycles and set by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, and `bus_req`, `bus_own`, `mem_ready`, `urgent`, `ref_done` and `backlog` are 0.
- R2: No request is raised and no strobe is driven low before `INIT_CYC` clock edges have passed since reset was released. The first request appears right after edge number `INIT_CYC`.
- R3: `mem_ready` rises in the cycle after the `WARMUP`-th `ref_done` pulse, and it then stays high until the next reset.
- R4: Once `mem_ready` is high, one refresh becomes due every `REFI_CYC` cycles, the first `REFI_CYC` cycles after ready. `backlog` goes up by one for each due refresh and down by one for each completed refresh.
- R5: `backlog` never exceeds `PEND_MAX`. A refresh that comes due while `backlog` equals `PEND_MAX` and no refresh is completing is dropped. `urgent` is high exactly when `backlog` equals `PEND_MAX`.
- R6: `bus_req` is 1 whenever refresh work is owed and the bus is not owned. A request that is not granted stays high in the next cycle. `bus_own` rises only in the cycle after an edge where `bus_req` and `bus_gnt` were both 1, and a grant without a request has no effect.
- R7: `cas_n` goes low exactly `T_CSR` cycles before `ras_n` goes low, and `we_n` is 1 when `ras_n` falls.
- R8: After `ras_n` falls, `cas_n` stays low for exactly `T_CHR` cycles and `ras_n` stays low for exactly `T_RAS` cycles.
- R9: Each ownership period lasts exactly `T_CSR + T_RC` cycles, and `ref_done` is high in its last cycle only.
- R10: While `bus_own` is 0, all three strobes are 1, and `we_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant from the access sequencer (ready side) |
| bus_req | output | 1 | Request for the strobe bus (valid side) |
| bus_own | output | 1 | Scheduler is driving the strobes |
| ref_done | output | 1 | Pulse in the last owned cycle of a refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| mem_ready | output | 1 | Power-up sequence complete |
| backlog | output | $clog2(PEND_MAX+1) | Refreshes due but not yet performed |
| urgent | output | 1 | Backlog is full |

## Verification
The hardest state to reach is a full backlog. Getting there needs `PEND_MAX` due refreshes with no grant in between, followed by further due ticks that must be dropped rather than wrap the counter. The stimulus withholds the grant for a window much longer than `PEND_MAX * REFI_CYC`. Before that window it gives random grants, with some grants arriving while nothing is requested. After the window it grants every cycle to drain the backlog. A bench model of the backlog is compared against the port every cycle.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } init_ph_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_PRE   = 2'd3
  } seq_st_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int REFI_CYC = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // timer never runs past its period
  p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int PEND_MAX = 8,
  localparam int BW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [BW-1:0] count,
  output logic          urgent
);
  localparam logic [BW-1:0] FULL = BW'(PEND_MAX);

  assign urgent = (count == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (tick && !take) begin
      if (count != FULL) count <= count + 1'b1;
    end else if (take && !tick) count <= count - 1'b1;
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && tick && !take) |=> urgent);
  p_take_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick) |-> count != '0);
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 2,
  parameter int T_RAS = 10,
  parameter int T_RC  = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic own,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int PRE_CYC = T_RC - T_RAS;
  localparam int MAXC    = (T_RAS > T_CSR) ? T_RAS : T_CSR;
  localparam int CW      = $clog2(((MAXC > PRE_CYC) ? MAXC : PRE_CYC) + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(T_CSR - 1);
  localparam logic [CW-1:0] ACT_LAST   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] HOLD_CYC   = CW'(T_CHR);

  seq_st_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          cnt <= '0;
          if (start) st <= SQ_SETUP;
        end
        SQ_SETUP: begin
          if (cnt == SETUP_LAST) begin st <= SQ_ACT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        SQ_ACT: begin
          if (cnt == ACT_LAST) begin st <= SQ_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        SQ_PRE: begin
          if (cnt == PRE_LAST) begin st <= SQ_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign own   = (st != SQ_IDLE);
  assign done  = (st == SQ_PRE) && (cnt == PRE_LAST);
  assign ras_n = !(st == SQ_ACT);
  assign cas_n = !((st == SQ_SETUP) || ((st == SQ_ACT) && (cnt < HOLD_CYC)));
  assign we_n  = 1'b1;

  // column strobe leads, write enable high at row strobe fall
  p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(!cas_n) && we_n));
  // column strobe only releases while the row strobe is still low
  p_cas_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n);
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !own) |=> own);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int INIT_CYC = 40000,
  parameter int WARMUP   = 8,
  parameter int REFI_CYC = 3125,
  parameter int PEND_MAX = 8,
  parameter int T_CSR    = 1,
  parameter int T_CHR    = 2,
  parameter int T_RAS    = 10,
  parameter int T_RC     = 17,
  localparam int BW      = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          bus_own,
  output logic          ref_done,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          mem_ready,
  output logic [BW-1:0] backlog,
  output logic          urgent
);
  localparam int PW = (INIT_CYC > 2) ? $clog2(INIT_CYC) : 1;
  localparam int WW = $clog2(WARMUP + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(INIT_CYC - 1);
  localparam logic [WW-1:0] WARM_N     = WW'(WARMUP);
  localparam logic [WW-1:0] WARM_ONE   = WW'(1);

  init_ph_t      phase;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] warm_left;
  logic          tick, take, start, want_ref, bl_urgent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pcnt      <= '0;
      warm_left <= '0;
    end else begin
      unique case (phase)
        PH_PAUSE: begin
          if (pcnt == PAUSE_LAST) begin
            phase     <= PH_WARM;
            warm_left <= WARM_N;
          end else pcnt <= pcnt + 1'b1;
        end
        PH_WARM: begin
          if (ref_done) begin
            warm_left <= warm_left - 1'b1;
            if (warm_left == WARM_ONE) phase <= PH_RUN;
          end
        end
        PH_RUN:  phase <= PH_RUN;
        default: phase <= PH_PAUSE;
      endcase
    end
  end

  assign mem_ready = (phase == PH_RUN);
  assign want_ref  = ((phase == PH_WARM) && (warm_left != '0)) ||
                     ((phase == PH_RUN) && (backlog != '0));
  assign bus_req   = want_ref && !bus_own;
  assign start     = bus_req && bus_gnt;
  assign take      = ref_done && (phase == PH_RUN);
  assign urgent    = bl_urgent && mem_ready;

  ref_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(mem_ready), .tick(tick)
  );

  ref_backlog #(.PEND_MAX(PEND_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
    .count(backlog), .urgent(bl_urgent)
  );

  ref_strobe_seq #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RC(T_RC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .own(bus_own), .done(ref_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (!bus_req && ras_n && cas_n));
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  p_own_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(bus_req && bus_gnt));
  p_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n && we_n));
endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
  localparam int INIT = 300;
  localparam int WARM = 8;
  localparam int REFI = 120;
  localparam int PMAX = 8;
  localparam int TCSR = 1;
  localparam int TCHR = 2;
  localparam int TRAS = 10;
  localparam int TRC  = 17;
  localparam int BW   = $clog2(PMAX + 1);
  localparam int RUN_CYC = 8500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, bus_own, ref_done, ras_n, cas_n, we_n, mem_ready, urgent;
  logic [BW-1:0] backlog;

  int total = 0, failed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .INIT_CYC(INIT), .WARMUP(WARM), .REFI_CYC(REFI), .PEND_MAX(PMAX),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RC(TRC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .bus_own(bus_own), .ref_done(ref_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .mem_ready(mem_ready), .backlog(backlog), .urgent(urgent)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected backlog after one edge, from the R4/R5 rules
  function automatic int next_backlog(input int cur, input bit due, input bit fin,
                                      output bit dropped);
    dropped = 1'b0;
    if (due && !fin) begin
      if (cur == PMAX) begin dropped = 1'b1; return cur; end
      return cur + 1;
    end
    if (fin && !due) return cur - 1;
    return cur;
  endfunction

  // bench state
  bit p_req, p_gnt, p_own, p_ras = 1'b1, p_cas = 1'b1, p_done;
  bit req_seen, ready_seen, urgent_seen;
  int rdy_i, warm_dones, mp, drops, cas_run, ras_run, own_run;

  task automatic observe(input int i);
    bit dr;
    // R2 pause quiet and first request timing
    if (i < INIT) chk(!bus_req && ras_n && cas_n && !bus_own, "R2", int'(bus_req), 0);
    if (!req_seen && bus_req) begin
      req_seen = 1'b1;
      chk(i == INIT, "R2", i, INIT);
    end
    // R3 warm-up burst then ready
    if (!ready_seen) begin
      if (mem_ready) begin
        ready_seen = 1'b1;
        rdy_i = i;
        chk(warm_dones == WARM, "R3", warm_dones, WARM);
        chk(p_done, "R3", int'(p_done), 1);
      end else if (ref_done) warm_dones++;
    end else begin
      chk(mem_ready, "R3", int'(mem_ready), 1);
      if (i > rdy_i) begin
        mp = next_backlog(mp, ((i - rdy_i) % REFI) == 0, p_done, dr);
        if (dr) drops++;
      end
      chk(int'(backlog) == mp, "R4", int'(backlog), mp);
      chk(urgent == (mp == PMAX), "R5", int'(urgent), int'(mp == PMAX));
      if (urgent) urgent_seen = 1'b1;
    end
    // R6 handshake
    if (p_req && !p_gnt) chk(bus_req, "R6", int'(bus_req), 1);
    if (p_req && p_gnt) chk(bus_own, "R6", int'(bus_own), 1);
    if (!p_own && bus_own) chk(p_req && p_gnt, "R6", int'(p_req && p_gnt), 1);
    // R10 idle strobes
    if (!bus_own) chk(ras_n && cas_n, "R10", int'({ras_n, cas_n}), 3);
    chk(we_n, "R10", int'(we_n), 1);
    // R7 / R8 strobe order and widths
    if (p_ras && !ras_n) begin
      chk(cas_run == TCSR, "R7", cas_run, TCSR);
      chk(we_n, "R7", int'(we_n), 1);
    end
    if (!p_cas && cas_n && !ras_n) chk(ras_run == TCHR, "R8", ras_run, TCHR);
    if (!p_ras && ras_n) chk(ras_run == TRAS, "R8", ras_run, TRAS);
    if (!ras_n) ras_run = p_ras ? 1 : ras_run + 1;
    if (!cas_n && ras_n) cas_run++;
    else if (cas_n) cas_run = 0;
    // R9 ownership length and completion pulse
    if (ref_done) chk(bus_own, "R9", int'(bus_own), 1);
    if (p_own && !bus_own) begin
      chk(own_run == TCSR + TRC, "R9", own_run, TCSR + TRC);
      chk(p_done, "R9", int'(p_done), 1);
    end
    own_run = bus_own ? own_run + 1 : 0;
    p_req = bus_req; p_own = bus_own; p_ras = ras_n; p_cas = cas_n;
    p_done = ref_done;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1", int'({ras_n, cas_n, we_n}), 7);
    chk(!bus_req && !bus_own && !ref_done, "R1", int'({bus_req, bus_own, ref_done}), 0);
    chk(!mem_ready && !urgent && backlog == '0, "R1", int'(backlog), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && ras_n && cas_n && !mem_ready, "R1", int'(bus_req), 0);
    p_req = bus_req; p_own = bus_own; p_done = ref_done;
    p_gnt = 1'b0;
    bus_gnt = 1'b1;  // grant without request during pause
    p_gnt = bus_gnt;
    for (int i = 2; i <= RUN_CYC; i++) begin
      @(negedge clk);
      observe(i);
      if (i < 4000)      bus_gnt = ($urandom_range(0, 99) < 30);
      else if (i < 6000) bus_gnt = 1'b0;
      else               bus_gnt = 1'b1;
      p_gnt = bus_gnt;
    end
    chk(req_seen, "R2", int'(req_seen), 1);
    chk(ready_seen, "R3", int'(ready_seen), 1);
    chk(urgent_seen, "R5", int'(urgent_seen), 1);
    chk(drops > 0, "R5", drops, 1);
    chk(backlog == '0, "R4", int'(backlog), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(5.0 * (RUN_CYC + 2000));
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule